// File: doc/BRIEF.md
# Multi-mode addressable bit latch

This block holds a small bank of single-bit storage cells (eight by default) that share one data input. A binary address picks one cell. Two active-low controls, an enable and a common clear, together select one of four modes. In the write mode, the addressed cell takes the data input and the other cells keep their contents. In the hold mode, every cell keeps its value. In the demultiplexer mode, the data input is steered to the addressed output and all other outputs are low. In the clear mode, every output and cell is low.

The cells are flip-flops that update on the rising clock edge. The outputs come from a combinational selector over the four modes. In write mode, the addressed output shows the data input at once, and the value held afterwards is the data present at the last clock edge before the enable returns high. If the data input is tied high, the demultiplexer mode works as an active-high binary-to-one-hot decoder. An asynchronous active-low system reset clears all cells. This reset is separate from the clear control. The address should only change while the block is in hold mode. The synchronous cells tolerate other address changes, but a source that is written for the asynchronous behaviour keeps to this rule.

Top module: `addr_bit_latch`

## Requirements
- R1: While rst_n is low, every cell is cleared asynchronously, and q reads all zero in hold mode (en_n=1, clr_n=1).
- R2: In write mode (en_n=0, clr_n=1), q[addr] equals din in the same cycle, and every other bit of q shows its stored value.
- R3: After one or more write-mode cycles, a rising edge stores din into cell addr. Once hold mode is entered, q[addr] shows the din value from the last write-mode edge. The other cells are unchanged.
- R4: In hold mode, q equals the stored cells and ignores din and addr across any number of clock edges.
- R5: In demultiplexer mode (en_n=0, clr_n=0), q[addr] equals din and all other bits of q are 0. Address bit 0 is the least significant bit, so addr=0 drives q[0] and addr=7 drives q[7].
- R6: In demultiplexer mode with din=1, q is the one-hot code 1<<addr.
- R7: In clear mode (en_n=1, clr_n=0), q is all zero whatever din and addr are, and a clock edge clears every cell, which is visible in the hold mode that follows.
- R8: A rising edge in demultiplexer mode leaves the cells holding (1<<addr) when din=1 and all zero when din=0. This is visible in the hold mode that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; cells update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low system reset of all cells |
| din | input | 1 | Single data input |
| addr | input | ADDR_W (3) | Cell / output select, bit 0 least significant |
| en_n | input | 1 | Active-low enable |
| clr_n | input | 1 | Active-low common clear |
| q | output | 2**ADDR_W (8) | Parallel outputs |

## Verification
The outputs for R2, R4, R5, R6 and R7 are combinational, so they are due in the same cycle as their inputs. The bench drives inputs on the falling edge and samples q five nanoseconds later, before the next rising edge. The stored results of R3, R7 and R8 are due one rising edge after the causing cycle. They are checked in the next cycle with the block in hold mode, so that only the cell contents reach q. The system reset of R1 acts without a clock, and it is checked within the same low phase in which it is asserted.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

   typedef enum logic [1:0] {
      MODE_HOLD  = 2'd0,
      MODE_WRITE = 2'd1,
      MODE_DEMUX = 2'd2,
      MODE_CLEAR = 2'd3
   } latch_mode_e;

   function automatic latch_mode_e mode_of(input logic en_n, input logic clr_n);
      latch_mode_e m;
      case ({en_n, clr_n})
         2'b01:   m = MODE_WRITE;
         2'b11:   m = MODE_HOLD;
         2'b00:   m = MODE_DEMUX;
         default: m = MODE_CLEAR;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/al_mode_decode.sv
module al_mode_decode
   import addr_latch_pkg::*;
(
   input  logic        en_n,
   input  logic        clr_n,
   output latch_mode_e mode
);
   always_comb mode = mode_of(en_n, clr_n);
endmodule

// File: rtl/al_onehot_dec.sv
module al_onehot_dec #(
   parameter int ADDR_W = 3,
   localparam int N_BITS = 1 << ADDR_W
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [N_BITS-1:0] sel
);
   for (genvar i = 0; i < N_BITS; i++) begin : g_sel
      assign sel[i] = (addr == ADDR_W'(i));
   end
endmodule

// File: rtl/al_store_bank.sv
module al_store_bank
   import addr_latch_pkg::*;
#(
   parameter int N_BITS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  latch_mode_e       mode,
   input  logic [N_BITS-1:0] sel,
   input  logic              din,
   output logic [N_BITS-1:0] cells
);
   for (genvar i = 0; i < N_BITS; i++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cells[i] <= 1'b0;
         end else begin
            case (mode)
               MODE_WRITE: if (sel[i]) cells[i] <= din;
               MODE_DEMUX: cells[i] <= sel[i] & din;
               MODE_CLEAR: cells[i] <= 1'b0;
               default:    cells[i] <= cells[i];
            endcase
         end
      end
   end
endmodule

// File: rtl/al_out_mux.sv
module al_out_mux
   import addr_latch_pkg::*;
#(
   parameter int N_BITS = 8
) (
   input  latch_mode_e       mode,
   input  logic [N_BITS-1:0] sel,
   input  logic              din,
   input  logic [N_BITS-1:0] cells,
   output logic [N_BITS-1:0] q
);
   logic [N_BITS-1:0] steered;
   assign steered = sel & {N_BITS{din}};

   always_comb begin
      case (mode)
         MODE_WRITE: q = (cells & ~sel) | steered;
         MODE_DEMUX: q = steered;
         MODE_CLEAR: q = '0;
         default:    q = cells;
      endcase
   end
endmodule

// File: rtl/addr_bit_latch.sv
module addr_bit_latch
   import addr_latch_pkg::*;
#(
   parameter int ADDR_W = 3,
   localparam int N_BITS = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              din,
   input  logic [ADDR_W-1:0] addr,
   input  logic              en_n,
   input  logic              clr_n,
   output logic [N_BITS-1:0] q
);
   if (ADDR_W < 1 || ADDR_W > 6) begin : g_bad_width
      $error("addr_bit_latch: ADDR_W must lie in 1..6");
   end

   latch_mode_e       mode;
   logic [N_BITS-1:0] sel;
   logic [N_BITS-1:0] cells;

   al_mode_decode u_mode (
      .en_n  (en_n),
      .clr_n (clr_n),
      .mode  (mode)
   );

   al_onehot_dec #(.ADDR_W(ADDR_W)) u_dec (
      .addr (addr),
      .sel  (sel)
   );

   al_store_bank #(.N_BITS(N_BITS)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (mode),
      .sel   (sel),
      .din   (din),
      .cells (cells)
   );

   al_out_mux #(.N_BITS(N_BITS)) u_mux (
      .mode  (mode),
      .sel   (sel),
      .din   (din),
      .cells (cells),
      .q     (q)
   );
endmodule

// File: rtl/al_latch_chk.sv
module al_latch_chk #(
   parameter int ADDR_W = 3,
   localparam int N_BITS = 1 << ADDR_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              din,
   input logic [ADDR_W-1:0] addr,
   input logic              en_n,
   input logic              clr_n,
   input logic [N_BITS-1:0] q
);
   // R1
   reset_zero_chk: assert property (@(posedge clk)
      (!rst_n && en_n && clr_n) |-> (q == '0));

   // R2
   write_show_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_n && clr_n) |-> (q[addr] == din));

   // R3
   write_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!en_n && clr_n) && en_n && clr_n) |-> (q[$past(addr)] == $past(din)));

   // R4
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en_n && clr_n) && en_n && clr_n) |-> $stable(q));

   // R5
   demux_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_n && !clr_n) |-> (q[addr] == din && $countones(q) == int'(din)));

   // R7
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_n && !clr_n) |-> (q == '0));
endmodule

bind addr_bit_latch al_latch_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .din   (din),
   .addr  (addr),
   .en_n  (en_n),
   .clr_n (clr_n),
   .q     (q)
);

// File: tb/addr_bit_latch_tb_top.sv
`timescale 1ns/1ps
module addr_bit_latch_tb_top;
   localparam int AW = 3;
   localparam int NB = 1 << AW;
   localparam time PERIOD = 20ns;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          din = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          en_n = 1'b1;
   logic          clr_n = 1'b1;
   logic [NB-1:0] q;

   int checks = 0;
   int errors = 0;
   logic [NB-1:0] model = '0;

   always #(PERIOD/2) clk = ~clk;

   addr_bit_latch #(.ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .din(din), .addr(addr),
      .en_n(en_n), .clr_n(clr_n), .q(q)
   );

   function automatic logic [NB-1:0] onehot(input logic [AW-1:0] a);
      return NB'(1) << a;
   endfunction

   function automatic logic [NB-1:0] exp_q(input logic [NB-1:0] st, input logic d,
                                           input logic [AW-1:0] a, input logic e, input logic c);
      logic [NB-1:0] r;
      case ({e, c})
         2'b01:   begin r = st; r[a] = d; end
         2'b11:   r = st;
         2'b00:   r = d ? onehot(a) : '0;
         default: r = '0;
      endcase
      return r;
   endfunction

   function automatic logic [NB-1:0] exp_next(input logic [NB-1:0] st, input logic d,
                                              input logic [AW-1:0] a, input logic e, input logic c);
      return (e && c) ? st : exp_q(st, d, a, e, c);
   endfunction

   function automatic string mode_tag(input logic e, input logic c, input logic d);
      case ({e, c})
         2'b01:   return "R2";
         2'b11:   return "R4";
         2'b00:   return d ? "R6" : "R5";
         default: return "R7";
      endcase
   endfunction

   task automatic check(input string tag, input logic [NB-1:0] expv);
      checks++;
      if (q !== expv) begin
         errors++;
         $display("FAIL %s q=%h expected %h", tag, q, expv);
      end
   endtask

   task automatic step(input logic d, input logic [AW-1:0] a, input logic e,
                       input logic c, input string tag);
      @(negedge clk);
      din = d; addr = a; en_n = e; clr_n = c;
      #5;
      check((tag == "") ? mode_tag(e, c, d) : tag, exp_q(model, d, a, e, c));
      @(posedge clk);
      model = exp_next(model, d, a, e, c);
   endtask

   initial begin
      #(PERIOD * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      // R1: reset state
      repeat (2) @(negedge clk);
      #5 check("R1", '0);
      @(negedge clk) rst_n = 1'b1;

      // R2 / R3: write then hold
      step(1'b1, 3'd5, 1'b0, 1'b1, "R2");
      step(1'b0, 3'd0, 1'b1, 1'b1, "R3");
      step(1'b1, 3'd0, 1'b0, 1'b1, "R2");
      step(1'b0, 3'd0, 1'b0, 1'b1, "R2");
      step(1'b1, 3'd6, 1'b1, 1'b1, "R3");
      step(1'b1, 3'd7, 1'b0, 1'b1, "R2");
      step(1'b0, 3'd7, 1'b1, 1'b1, "R3");
      // R4: hold ignores din and addr
      for (int k = 0; k < 4; k++)
         step(1'($urandom), AW'($urandom), 1'b1, 1'b1, "R4");
      // R5 / R6 / R8: demultiplexer and decoder, then hold
      step(1'b1, 3'd7, 1'b0, 1'b0, "R6");
      step(1'b1, 3'd0, 1'b0, 1'b0, "R6");
      step(1'b0, 3'd3, 1'b0, 1'b0, "R5");
      step(1'b0, 3'd3, 1'b1, 1'b1, "R8");
      step(1'b1, 3'd2, 1'b0, 1'b0, "R6");
      step(1'b0, 3'd5, 1'b1, 1'b1, "R8");
      // R7: clear mode, then hold
      step(1'b1, 3'd1, 1'b0, 1'b1, "R2");
      step(1'b1, 3'd4, 1'b1, 1'b0, "R7");
      step(1'b1, 3'd4, 1'b1, 1'b1, "R7");
      // random mix
      for (int k = 0; k < 500; k++)
         step(1'($urandom), AW'($urandom), 1'($urandom), 1'($urandom), "");
      // R1: asynchronous reset mid-run
      step(1'b1, 3'd3, 1'b0, 1'b1, "R2");
      @(negedge clk);
      en_n = 1'b1; clr_n = 1'b1; rst_n = 1'b0;
      #5 check("R1", '0);
      model = '0;
      @(negedge clk) rst_n = 1'b1;
      step(1'b0, 3'd0, 1'b1, 1'b1, "R1");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule